// File: doc/BRIEF.md
# Serial Divider Word Loader

This block is the programming front end of a frequency synthesizer. A host sends a word one bit at a time over a serial data line, with one shift strobe per bit. The bits enter a shift register most significant bit first. The final bit of each word is a steering flag. When the host raises the load enable, the register contents are copied into one of two holding registers, chosen by that flag.

- A flag of 1 selects the 14-bit reference divider word.
- A flag of 0 selects the loop divider word.

The holding registers feed the synthesizer's counters and are also brought out as ports.

A parameter selects between two loop divider formats:

- **Single-modulus:** the loop divider is one 14-bit value.
- **Dual-modulus:** the loop divider is split into a 10-bit main count and a 7-bit swallow count. This is the default.

The bit leaving the far end of the shift register is driven on a serial output, so the register can be read back or chained. The whole block runs on one system clock. The shift strobe and the load enable are qualifiers that are sampled on that clock.

Top module: `divider_load_port`

## Requirements
- R1: A synchronous active-high reset clears the shift register, both holding registers and the swallow count to zero, so the serial output reads 0.
- R2: On every clock edge with `shift_en` high, `ser_din` enters bit 0 of the shift register and the other bits move one place up. With `shift_en` low the register keeps its value.
- R3: `ser_dout` always shows the top bit of the shift register. A word shifted in can therefore be recovered, most significant bit first, by shifting further.
- R4: On an edge with `load_en` high while register bit 0 is 1, `ref_div` takes register bits 14..1 (bit 1 is the least significant). Register bits above 14 are ignored, and the loop divider outputs keep their values.
- R5: In the dual-modulus variant, on an edge with `load_en` high while register bit 0 is 0:
  - `n_div` takes register bits 17..8.
  - `a_div` takes bits 7..1.
  - `ref_div` keeps its value.
- R6: While `load_en` is low, `ref_div`, `n_div` and `a_div` hold their values, however much data is shifted.
- R7: The load is level sensitive. On every edge with `load_en` high, the selected holding register is rewritten from the register's value before that edge, so it follows the shifting data one cycle behind.
- R8: In the single-modulus variant (`DUAL_MOD` = 0), the shift register is 15 bits long.
  - A load with bit 0 equal to 0 puts register bits 14..1 into the 14-bit `n_div`.
  - `a_div` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Shift strobe, one bit per qualified edge |
| ser_din | input | 1 | Serial data, most significant bit first |
| load_en | input | 1 | Level load enable for the holding registers |
| ser_dout | output | 1 | Bit at the far end of the shift register |
| ref_div | output | 14 | Reference divider word |
| n_div | output | NW (10 dual, 14 single) | Loop divider main count |
| a_div | output | 7 | Swallow count (0 in single-modulus variant) |

## Verification
The hardest case to reach is a load that coincides with shifting. The selected destination can change in the middle of the load window when a new bit lands in position 0. The holding register must then capture the pre-edge contents, not the freshly shifted ones.

The stimulus holds `load_en` high across many shift strobes, and mixes random strobe and load patterns. Both holding registers are therefore rewritten in alternation as the steering bit flips. A reference model checks every cycle.

// File: rtl/dlp_pkg.sv
package dlp_pkg;

    localparam int REF_W    = 14;
    localparam int N_WIDE_W = 14;
    localparam int N_DM_W   = 10;
    localparam int A_W      = 7;

    typedef enum logic {
        DEST_DIV = 1'b0,
        DEST_REF = 1'b1
    } dest_e;

    typedef struct packed {
        logic [N_DM_W-1:0] n;
        logic [A_W-1:0]    a;
    } dm_word_t;

    function automatic int payload_w(bit dual);
        return dual ? (N_DM_W + A_W) : N_WIDE_W;
    endfunction

    function automatic int n_width(bit dual);
        return dual ? N_DM_W : N_WIDE_W;
    endfunction

endpackage

// File: rtl/dlp_shift.sv
module dlp_shift #(
    parameter int W = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          shift_en,
    input  logic          din,
    output logic [W-1:0]  q,
    output logic          dout,
    output dlp_pkg::dest_e dest
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[W-2:0], din};
        end
    end

    assign dout = q[W-1];
    assign dest = dlp_pkg::dest_e'(q[0]);
endmodule

// File: rtl/dlp_hold.sv
module dlp_hold #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/divider_load_port.sv
module divider_load_port #(
    parameter bit   DUAL_MOD = 1'b1,
    localparam int  PW  = dlp_pkg::payload_w(DUAL_MOD),
    localparam int  SRW = PW + 1,
    localparam int  NW  = dlp_pkg::n_width(DUAL_MOD)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shift_en,
    input  logic                     ser_din,
    input  logic                     load_en,
    output logic                     ser_dout,
    output logic [dlp_pkg::REF_W-1:0] ref_div,
    output logic [NW-1:0]            n_div,
    output logic [dlp_pkg::A_W-1:0]  a_div
);
    import dlp_pkg::*;

    logic [SRW-1:0] sr_q;
    dest_e          dest;
    logic           load_ref;
    logic           load_div;

    dlp_shift #(.W(SRW)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (ser_din),
        .q        (sr_q),
        .dout     (ser_dout),
        .dest     (dest)
    );

    assign load_ref = load_en && (dest == DEST_REF);
    assign load_div = load_en && (dest == DEST_DIV);

    dlp_hold #(.W(REF_W)) u_ref (
        .clk  (clk),
        .rst  (rst),
        .load (load_ref),
        .d    (sr_q[REF_W:1]),
        .q    (ref_div)
    );

    generate
        if (DUAL_MOD) begin : g_dual
            dm_word_t word;
            assign word = dm_word_t'(sr_q[PW:1]);

            dlp_hold #(.W(NW)) u_n (
                .clk  (clk),
                .rst  (rst),
                .load (load_div),
                .d    (word.n),
                .q    (n_div)
            );

            dlp_hold #(.W(A_W)) u_a (
                .clk  (clk),
                .rst  (rst),
                .load (load_div),
                .d    (word.a),
                .q    (a_div)
            );
        end else begin : g_single
            dlp_hold #(.W(NW)) u_n (
                .clk  (clk),
                .rst  (rst),
                .load (load_div),
                .d    (sr_q[PW:1]),
                .q    (n_div)
            );

            assign a_div = '0;
        end
    endgenerate
endmodule

// File: rtl/dlp_chk.sv
module dlp_chk #(
    parameter bit DUAL_MOD = 1'b1,
    parameter int SRW      = 18,
    parameter int NW       = 10
) (
    input logic           clk,
    input logic           rst,
    input logic           shift_en,
    input logic           ser_din,
    input logic           load_en,
    input logic           ser_dout,
    input logic [SRW-1:0] sr,
    input logic [13:0]    ref_div,
    input logic [NW-1:0]  n_div,
    input logic [6:0]     a_div
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (sr == '0 && ref_div == '0 && n_div == '0 && a_div == '0));

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> sr[0] == $past(ser_din));

    assert_no_shift_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sr));

    assert_dout_moves_R3: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> ser_dout == $past(sr[SRW-2]));

    assert_ref_load_R4: assert property (@(posedge clk) disable iff (rst)
        (load_en && sr[0]) |=> ref_div == $past(sr[14:1]));

    assert_ref_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (load_en && !sr[0]) |=> $stable(ref_div));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> ($stable(ref_div) && $stable(n_div) && $stable(a_div)));

    generate
        if (DUAL_MOD) begin : g_dual
            assert_dm_load_R5: assert property (@(posedge clk) disable iff (rst)
                (load_en && !sr[0]) |=>
                    (n_div == $past(sr[SRW-1:8]) && a_div == $past(sr[7:1])));
        end else begin : g_single
            assert_n_load_R8: assert property (@(posedge clk) disable iff (rst)
                (load_en && !sr[0]) |=> (n_div == $past(sr[SRW-1:1]) && a_div == '0));
        end
    endgenerate
endmodule

bind divider_load_port dlp_chk #(
    .DUAL_MOD (DUAL_MOD),
    .SRW      (SRW),
    .NW       (NW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .ser_din  (ser_din),
    .load_en  (load_en),
    .ser_dout (ser_dout),
    .sr       (sr_q),
    .ref_div  (ref_div),
    .n_div    (n_div),
    .a_div    (a_div)
);

// File: tb/test_divider_load_port.sv
`timescale 1ns/1ps
module test_divider_load_port;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic shift_en = 1'b0;
    logic ser_din = 1'b0;
    logic load_en = 1'b0;

    logic        dout_d, dout_s;
    logic [13:0] ref_d, ref_s;
    logic [9:0]  n_d;
    logic [13:0] n_s;
    logic [6:0]  a_d, a_s;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    string phase = "main";

    // reference model
    logic [17:0] m_sr_d;
    logic [14:0] m_sr_s;
    logic [13:0] m_ref_d, m_ref_s, m_n_s;
    logic [9:0]  m_n_d;
    logic [6:0]  m_a_d;

    always #2 clk = ~clk;

    divider_load_port i_divider_load_port (
        .clk(clk), .rst(rst), .shift_en(shift_en), .ser_din(ser_din),
        .load_en(load_en), .ser_dout(dout_d), .ref_div(ref_d),
        .n_div(n_d), .a_div(a_d)
    );

    divider_load_port #(.DUAL_MOD(1'b0)) i_divider_load_port_n14 (
        .clk(clk), .rst(rst), .shift_en(shift_en), .ser_din(ser_din),
        .load_en(load_en), .ser_dout(dout_s), .ref_div(ref_s),
        .n_div(n_s), .a_div(a_s)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_sr_d = '0; m_sr_s = '0; m_ref_d = '0; m_ref_s = '0;
            m_n_d = '0; m_a_d = '0; m_n_s = '0;
        end else begin
            if (load_en) begin
                if (m_sr_d[0]) m_ref_d = m_sr_d[14:1];
                else begin m_n_d = m_sr_d[17:8]; m_a_d = m_sr_d[7:1]; end
                if (m_sr_s[0]) m_ref_s = m_sr_s[14:1];
                else m_n_s = m_sr_s[14:1];
            end
            if (shift_en) begin
                m_sr_d = {m_sr_d[16:0], ser_din};
                m_sr_s = {m_sr_s[13:0], ser_din};
            end
        end
    endtask

    // called at a negedge: drive, take the edge, check at the next negedge
    task automatic step(input logic sh, input logic d, input logic ld);
        shift_en = sh; ser_din = d; load_en = ld;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk($sformatf("R2 R3 dout dual %s", phase), dout_d, m_sr_d[17]);
        chk($sformatf("R2 R3 dout single %s", phase), dout_s, m_sr_s[14]);
        chk($sformatf("R4 ref dual %s", phase), ref_d, m_ref_d);
        chk($sformatf("R4 ref single %s", phase), ref_s, m_ref_s);
        chk($sformatf("R5 n dual %s", phase), n_d, m_n_d);
        chk($sformatf("R5 a dual %s", phase), a_d, m_a_d);
        chk($sformatf("R8 n single %s", phase), n_s, m_n_s);
        chk($sformatf("R8 a single %s", phase), a_s, 0);
    endtask

    task automatic send(input logic [17:0] w);
        for (int i = 17; i >= 0; i--) step(1'b1, w[i], 1'b0);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [13:0] keep_ref_d, keep_ref_s, keep_n_s;
        logic [9:0]  keep_n_d;
        logic [6:0]  keep_a_d;
        logic [17:0] probe;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        rst = 1'b1;
        phase = "reset";
        step(1'b1, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        // R1: everything zero after reset
        chk("R1 ref", ref_d, 0); chk("R1 n", n_d, 0); chk("R1 a", a_d, 0);
        chk("R1 dout", dout_d, 0); chk("R1 ref single", ref_s, 0);
        rst = 1'b0;

        // R4: reference word, upper bits ignored
        phase = "ref";
        send({3'b101, 14'h2A5C, 1'b1});
        chk("R4 ref dual direct", ref_d, 14'h2A5C);
        chk("R4 ref single direct", ref_s, 14'h2A5C);
        chk("R4 n untouched", n_d, 0);

        // R5: dual loop word
        phase = "div";
        send({10'h2B7, 7'h55, 1'b0});
        chk("R5 n direct", n_d, 10'h2B7);
        chk("R5 a direct", a_d, 7'h55);
        chk("R5 ref kept", ref_d, 14'h2A5C);

        // R8: single loop word
        phase = "single";
        send({4'b0000, 14'h3A1B, 1'b0});
        chk("R8 n single direct", n_s, 14'h3A1B);
        chk("R8 a single zero", a_s, 0);

        // R6: long shifting with load low keeps latches
        phase = "R6";
        keep_ref_d = ref_d; keep_n_d = n_d; keep_a_d = a_d;
        keep_ref_s = ref_s; keep_n_s = n_s;
        for (int i = 0; i < 40; i++) step(1'b1, 1'($urandom), 1'b0);
        chk("R6 ref held", ref_d, keep_ref_d);
        chk("R6 n held", n_d, keep_n_d);
        chk("R6 a held", a_d, keep_a_d);
        chk("R6 ref single held", ref_s, keep_ref_s);
        chk("R6 n single held", n_s, keep_n_s);

        // R7: load held high while shifting, destination flips
        phase = "R7";
        for (int i = 0; i < 40; i++) step(1'b1, 1'($urandom), 1'b1);
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        chk("R7 ref follows", ref_d, m_sr_d[14:1]);

        // R3: read a word back out through ser_dout
        phase = "R3";
        probe = 18'h2C3A5;
        for (int i = 17; i >= 0; i--) step(1'b1, probe[i], 1'b0);
        for (int i = 17; i >= 0; i--) begin
            chk("R3 readback", dout_d, probe[i]);
            step(1'b1, 1'b0, 1'b0);
        end

        // random mix
        phase = "random";
        for (int i = 0; i < 1500; i++)
            step(1'(($urandom % 4) != 0), 1'($urandom), 1'(($urandom % 5) == 0));

        // R1 again mid-run
        phase = "reset2";
        rst = 1'b1;
        step(1'b1, 1'b1, 1'b1);
        chk("R1 ref after reset", ref_d, 0);
        chk("R1 n single after reset", n_s, 0);
        rst = 1'b0;
        step(1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule